// File: doc/BRIEF.md
# Replay-Capable Word FIFO

This block is a single-clock first-in/first-out buffer for 9-bit words. The ninth bit is free for parity or a framing marker. A producer pulses a write strobe for one clock to store a word. A consumer pulses a read strobe for one clock to fetch the oldest unread word. The fetched word appears on a registered output together with a one-cycle valid pulse.

Three active-low status outputs describe the occupancy, which is the write pointer minus the read pointer:

- `empty_n` is low when nothing is left unread.
- `full_n` is low when every slot holds an unread word.
- `half_n` is low while more than half of the slots are occupied.

Strobes that would overflow or underflow the buffer are ignored. An active-low rewind input returns the read pointer to the first slot and leaves the write pointer alone. A consumer uses it to replay a short message (fewer than DEPTH words since reset) from its start. Both pointers carry one wrap bit beyond the address bits, so an equal address with a different wrap bit means full. An active-low synchronous reset clears both pointers.

Top module: `rtx_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `rd_valid` is 0.
- R2: Each accepted read drives the oldest unread word onto `rd_data`, with all 9 bits intact, and pulses `rd_valid` to 1 in the cycle after the strobe. `rd_valid` is 1 only after an accepted read.
- R3: With no reads since reset, `full_n` goes to 0 after exactly DEPTH accepted writes. While `full_n` is 0, write strobes change neither the pointers nor the stored words.
- R4: While `empty_n` is 0, a read strobe is ignored. `rd_valid` stays 0 and the next word written is the next word read.
- R5: `half_n` is 0 exactly when the occupancy exceeds DEPTH/2. It asserts on the write that crosses that level and releases on the read that returns to it. It is always 0 when `full_n` is 0.
- R6: A read strobe and a write strobe in the same cycle, when neither flag blocks them, leave the occupancy and therefore all three flags unchanged, and keep first-in/first-out order.
- R7: A cycle with `rewind_n` low sets the read pointer to slot zero and keeps the write pointer. The flags then reflect the new occupancy, and subsequent reads replay the words from the first one written after reset.
- R8: When `rst_n` and `rewind_n` are both low, the reset result of R1 applies.
- R9: A write into an empty buffer sets `empty_n` to 1 in the next cycle, so that word can be read then.
- R10: A read strobe in a cycle with `rewind_n` low is ignored, and `rd_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_stb | input | 1 | Write strobe, one cycle per word |
| wr_data | input | DATA_W (9) | Word to store |
| rd_stb | input | 1 | Read strobe, one cycle per word |
| rewind_n | input | 1 | Active-low rewind of the read pointer to slot zero |
| rd_data | output | DATA_W (9) | Registered word from the last accepted read |
| rd_valid | output | 1 | High for one cycle when `rd_data` carries a new word |
| empty_n | output | 1 | Low when no unread word remains |
| full_n | output | 1 | Low when all DEPTH slots hold unread words |
| half_n | output | 1 | Low while occupancy exceeds DEPTH/2 |

## Verification

The bench fills the buffer to the brim and pushes extra writes against the full flag. A design without a wrap bit, or with a leaky write gate, would either never report full or would overwrite the oldest word, and the read-back of all DEPTH words would show it. Reads against an empty buffer, and reads issued during a rewind, are aimed at designs that advance the read pointer anyway: such a design would raise a spurious valid pulse and then return a misaligned word.

The half-full threshold is watched on every step, so a flag that trips at DEPTH/2 instead of above it is caught one write early. The bench also replays a short message after a rewind and issues coincident read/write cycles. A rewind that disturbed the write pointer would return the wrong sequence, and an occupancy update that dropped one side of a coincident cycle would move the flags.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

   // Pointer update selected each cycle
   typedef enum logic [1:0] {
      PTR_HOLD = 2'd0,
      PTR_STEP = 2'd1,
      PTR_ZERO = 2'd2
   } ptr_op_e;

   // Address width for a given depth (at least one bit)
   function automatic int addr_bits(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/rtx_ptr.sv
module rtx_ptr #(
   parameter int AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rtx_pkg::ptr_op_e  op,
   output logic [AW:0]       ptr
);
   import rtx_pkg::*;

   // Reset outranks every other operation
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else begin
         unique case (op)
            PTR_STEP: ptr <= ptr + 1'b1;
            PTR_ZERO: ptr <= '0;
            default:  ptr <= ptr;
         endcase
      end
   end

endmodule

// File: rtl/rtx_store.sv
module rtx_store #(
   parameter int DATA_W = 9,
   parameter int DEPTH  = 16,
   parameter int AW     = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] words [DEPTH];
   logic [DEPTH-1:0]  slot_we;

   // One decoded enable per slot
   for (genvar i = 0; i < DEPTH; i++) begin : g_dec
      assign slot_we[i] = we && (waddr == AW'(i));
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (slot_we[i]) words[i] <= wdata;
      end
   end

   assign rdata = words[raddr];

endmodule

// File: rtl/rtx_flags.sv
module rtx_flags #(
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic [AW:0] wptr,
   input  logic [AW:0] rptr,
   output logic        empty_n,
   output logic        full_n,
   output logic        half_n
);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
   localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH / 2);

   logic [AW:0] occ;

   // The wrap bit makes the modular difference exact from 0 to DEPTH
   assign occ     = wptr - rptr;
   assign empty_n = (occ != '0);
   assign full_n  = (occ != FULL_CNT);
   assign half_n  = !(occ > HALF_CNT);

endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo #(
   parameter int DATA_W = 9,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_stb,
   input  logic              rewind_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              empty_n,
   output logic              full_n,
   output logic              half_n
);
   import rtx_pkg::*;

   localparam int AW = addr_bits(DEPTH);

   // Elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rtx_fifo: DEPTH must be a power of two and at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rtx_fifo: DATA_W must be positive");
   end

   logic [AW:0]       wptr, rptr;
   logic              wr_go, rd_go;
   ptr_op_e           wop, rop;
   logic [DATA_W-1:0] mem_q;

   // Flags gate the strobes; a rewind cycle suppresses reads
   assign wr_go = rst_n && wr_stb && full_n;
   assign rd_go = rst_n && rewind_n && rd_stb && empty_n;

   always_comb begin
      wop = wr_go ? PTR_STEP : PTR_HOLD;
   end

   always_comb begin
      if (!rewind_n)  rop = PTR_ZERO;
      else if (rd_go) rop = PTR_STEP;
      else            rop = PTR_HOLD;
   end

   rtx_ptr #(.AW(AW)) u_wptr (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (wop),
      .ptr   (wptr)
   );

   rtx_ptr #(.AW(AW)) u_rptr (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (rop),
      .ptr   (rptr)
   );

   rtx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
      .clk   (clk),
      .we    (wr_go),
      .waddr (wptr[AW-1:0]),
      .wdata (wr_data),
      .raddr (rptr[AW-1:0]),
      .rdata (mem_q)
   );

   rtx_flags #(.DEPTH(DEPTH), .AW(AW)) u_flags (
      .wptr    (wptr),
      .rptr    (rptr),
      .empty_n (empty_n),
      .full_n  (full_n),
      .half_n  (half_n)
   );

   // Registered output word and its valid pulse
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_go;
         if (rd_go) rd_data <= mem_q;
      end
   end

endmodule

// File: rtl/rtx_fifo_chk.sv
module rtx_fifo_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_stb,
   input logic rd_stb,
   input logic rewind_n,
   input logic rd_valid,
   input logic empty_n,
   input logic full_n,
   input logic half_n
);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (!empty_n && full_n && half_n && !rd_valid));

   // R2
   valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_stb && empty_n && rewind_n));

   // R3
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && wr_stb && !rd_stb && rewind_n) |=> !full_n);

   // R4
   empty_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && rd_stb && !wr_stb && rewind_n) |=> (!empty_n && !rd_valid));

   // R5
   half_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> !half_n);

   // R6
   balanced_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_n && full_n && rd_stb && wr_stb && rewind_n) |=>
         ($stable(empty_n) && $stable(full_n) && $stable(half_n)));

   // R9
   first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && wr_stb) |=> empty_n);

   // R10
   rewind_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rewind_n |=> !rd_valid);

endmodule

bind rtx_fifo rtx_fifo_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_stb   (wr_stb),
   .rd_stb   (rd_stb),
   .rewind_n (rewind_n),
   .rd_valid (rd_valid),
   .empty_n  (empty_n),
   .full_n   (full_n),
   .half_n   (half_n)
);

// File: tb/sim_rtx_fifo.sv
module sim_rtx_fifo;

   localparam int DEPTH = 16;
   localparam int DW    = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_stb = 1'b0;
   logic          rewind_n = 1'b1;
   logic [DW-1:0] rd_data;
   logic          rd_valid, empty_n, full_n, half_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [DW-1:0] wlist [$];
   logic [DW-1:0] exp_q [$];
   int            rd_idx = 0;

   always #10 clk = ~clk;

   rtx_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_stb(rd_stb), .rewind_n(rewind_n), .rd_data(rd_data),
      .rd_valid(rd_valid), .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int i);
      logic [7:0] b;
      b = 8'(i * 37 + 5);
      return {^b, b};
   endfunction

   // Driver: one clock of stimulus, model update, flag checks after the edge
   task automatic step(input bit rs, input bit w, input logic [DW-1:0] d,
                       input bit r, input bit rt);
      bit wa, ra;
      int mc;
      @(negedge clk);
      rst_n = rs; wr_stb = w; wr_data = d; rd_stb = r; rewind_n = !rt;
      wa = 1'b0; ra = 1'b0;
      if (!rs) begin
         wlist.delete(); exp_q.delete(); rd_idx = 0;
      end else begin
         mc = wlist.size() - rd_idx;
         wa = w && (mc < DEPTH);
         ra = r && !rt && (mc > 0);
         if (ra) begin exp_q.push_back(wlist[rd_idx]); rd_idx++; end
         if (wa) wlist.push_back(d);
         if (rt) rd_idx = 0;
      end
      @(posedge clk); #5;
      mc = wlist.size() - rd_idx;
      chk(empty_n === (mc != 0), "R4/R9 empty_n", int'(empty_n), int'(mc != 0));
      chk(full_n === (mc != DEPTH), "R3 full_n", int'(full_n), int'(mc != DEPTH));
      chk(half_n === !(mc > DEPTH/2), "R5 half_n", int'(half_n), int'(!(mc > DEPTH/2)));
      chk(rd_valid === ra, "R2/R10 rd_valid", int'(rd_valid), int'(ra));
   endtask

   // Monitor: compare every delivered word with the scoreboard
   always @(posedge clk) begin
      #5;
      if (rd_valid === 1'b1) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected word", int'(rd_data), -1);
         end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            chk(rd_data === e, "R2 data", int'(rd_data), int'(e));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      step(0, 0, '0, 0, 0);
      step(0, 0, '0, 0, 0);
      chk(rd_valid === 1'b0 && empty_n === 1'b0, "R1 reset outputs", int'(empty_n), 0);

      // R2: order and all 9 bits, including the top bit
      step(1, 1, 9'h1F0, 0, 0);
      step(1, 1, 9'h00F, 0, 0);
      step(1, 1, 9'h155, 0, 0);
      for (int i = 0; i < 4; i++) step(1, 0, '0, 1, 0);

      // R4: reads against empty, then a fresh word must still come out first
      step(1, 0, '0, 1, 0);
      step(1, 0, '0, 1, 0);
      // R9: write into empty, read in the very next cycle
      step(1, 1, 9'h0A5, 0, 0);
      chk(empty_n === 1'b1, "R9 readable next cycle", int'(empty_n), 1);
      step(1, 0, '0, 1, 0);

      // R3/R5: fill to DEPTH, push extra writes, drain everything
      for (int i = 0; i < DEPTH; i++) step(1, 1, pat(i), 0, 0);
      chk(full_n === 1'b0, "R3 full after DEPTH writes", int'(full_n), 0);
      step(1, 1, 9'h1AA, 0, 0);
      step(1, 1, 9'h0BB, 0, 0);
      // R6: coincident read and write while full: the read alone is accepted
      step(1, 1, 9'h0CC, 1, 0);
      for (int i = 0; i < DEPTH + 1; i++) step(1, 0, '0, 1, 0);

      // R7: replay after rewind
      step(0, 0, '0, 0, 0);
      for (int i = 0; i < 5; i++) step(1, 1, pat(100 + i), 0, 0);
      step(1, 0, '0, 1, 0);
      step(1, 0, '0, 1, 0);
      // R10: read strobe during rewind is ignored
      step(1, 0, '0, 1, 1);
      chk(rd_valid === 1'b0, "R10 no read on rewind", int'(rd_valid), 0);
      chk(empty_n === 1'b1 && full_n === 1'b1, "R7 flags after rewind", int'(empty_n), 1);
      for (int i = 0; i < 5; i++) step(1, 0, '0, 1, 0);

      // R6: coincident read and write keep the flags steady
      for (int i = 0; i < 10; i++) step(1, 1, pat(200 + i), 0, 0);
      for (int i = 0; i < 6; i++) begin
         logic e0, f0, h0;
         e0 = empty_n; f0 = full_n; h0 = half_n;
         step(1, 1, pat(300 + i), 1, 0);
         chk(empty_n === e0 && full_n === f0 && half_n === h0,
             "R6 flags steady", int'({empty_n, full_n, half_n}), int'({e0, f0, h0}));
      end

      // R8: reset together with rewind
      step(0, 0, '0, 0, 1);
      chk(empty_n === 1'b0 && full_n === 1'b1 && half_n === 1'b1,
          "R8 reset wins", int'({empty_n, full_n, half_n}), 3);
      step(1, 0, '0, 1, 0);
      step(1, 0, '0, 0, 0);
      chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule